// File: doc/BRIEF.md
# Binary64 exponent extractor

This unit takes one IEEE-754 binary64 operand and returns the integer part of the base-two logarithm of its magnitude, floor(log2(|x|)). The result is itself encoded as a binary64 value. The sign of the operand plays no part in the numeric result. For a subnormal operand, the unit finds the leading one of the fraction and reports the true, more negative exponent. It also raises a denormal flag in that case.

A denormals-are-zero control makes any operand with a zero exponent field behave as zero. NaN inputs pass through as quiet NaNs, and a signaling NaN raises an invalid flag. Infinities give +infinity and zeros give -infinity. The integer-to-binary64 step is always exact, so no rounding-mode input exists.

The unit registers its inputs' result once, so a value driven before a rising clock edge appears on the outputs after that edge.

Top module: `dp_exp_extract`

## Requirements
- R1: While rst_n is low, res_o, inv_o and den_o are all zero.
- R2: The outputs show the result for the operand and control present at the previous rising clock edge. The sign bit (63) of a non-NaN operand does not change the result.
- R3: An operand with exponent field (bits 62:52) all ones and a nonzero fraction (bits 51:0) is a NaN. Its result keeps the sign and every fraction bit except bit 51, which is forced to one.
- R4: inv_o is 1 exactly when the operand is a NaN whose fraction bit 51 is 0 (signaling); a quiet NaN gives inv_o = 0.
- R5: An exponent field of all ones with a zero fraction, of either sign, gives +infinity, 0x7FF0000000000000.
- R6: An exponent field of 0 with a zero fraction gives -infinity, 0xFFF0000000000000, of either sign. With daz_i = 1, any operand whose exponent field is 0 also gives -infinity, and den_o stays 0.
- R7: A normal operand (exponent field e between 1 and 2046) gives the binary64 encoding of e - 1023. An integer of 0 encodes as 0x0000000000000000.
- R8: A subnormal operand (exponent field 0, fraction nonzero, daz_i = 0) gives -1023 minus the number of leading zeros in fraction bits 51:0, from -1023 down to -1074, and sets den_o = 1.
- R9: Every integer result is converted exactly. The result's fraction bits 41:0 are zero whenever the result is neither a NaN nor an infinity.
- R10: inv_o and den_o are never both 1. den_o is 1 only when the result is negative, with an exponent field of 1032 or 1033.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 64 | Binary64 operand |
| daz_i | input | 1 | Treat zero-exponent operands as zero |
| res_o | output | 64 | Binary64 floor(log2(\|x\|)) |
| inv_o | output | 1 | Signaling NaN seen |
| den_o | output | 1 | Subnormal operand normalized |

## Verification
The assertions watch the output relations that must hold on every cycle. The invalid flag appears only beside a quiet-NaN result, and the two flags never rise together. A denormal flag always comes with a negative result in the subnormal exponent band. Every finite result leaves its low fraction bits clear. Only the bench's scenarios can show that the numeric value is right for each operand class. The same holds for the leading-zero normalization across all 52 fraction positions, sign independence, and the effect of the denormals-are-zero control.

// File: rtl/dp_exp_extract.sv
module dp_exp_extract #(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EW+FW:0]    op_i,
  input  logic              daz_i,
  output logic [EW+FW:0]    res_o,
  output logic              inv_o,
  output logic              den_o
);
  localparam int DW   = EW + FW + 1;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int IW   = EW + 1;
  localparam int LW   = $clog2(FW + 1);
  localparam int PW   = $clog2(EW + 1);

  function automatic logic [LW-1:0] lead_zeros(input logic [FW-1:0] f);
    logic [LW-1:0] cnt;
    logic          hit;
    cnt = '0;
    hit = 1'b0;
    for (int i = FW - 1; i >= 0; i--) begin
      if (!hit) begin
        if (f[i]) hit = 1'b1;
        else      cnt = cnt + 1'b1;
      end
    end
    return cnt;
  endfunction

  function automatic logic [DW-1:0] int_to_fp(input logic signed [IW-1:0] n);
    logic [IW-1:0]  mag;
    logic [PW-1:0]  p;
    logic [FW:0]    m;
    if (n == '0) return '0;
    mag = n[IW-1] ? IW'(-n) : IW'(n);
    p = '0;
    for (int i = 0; i < IW; i++)
      if (mag[i]) p = PW'(i);
    m = {{(FW+1-IW){1'b0}}, mag} << (FW - int'(p));
    return {n[IW-1], EW'(BIAS + int'(p)), m[FW-1:0]};
  endfunction

  logic [EW-1:0]        e;
  logic [FW-1:0]        f;
  logic                 is_nan, is_inf, is_zero, is_sub;
  logic signed [IW-1:0] n;
  logic [DW-1:0]        res_d;

  assign e       = op_i[DW-2:FW];
  assign f       = op_i[FW-1:0];
  assign is_nan  = (&e) && (f != '0);
  assign is_inf  = (&e) && (f == '0);
  assign is_zero = (e == '0) && ((f == '0) || daz_i);
  assign is_sub  = (e == '0) && (f != '0) && !daz_i;

  always_comb begin
    if (is_sub) n = IW'(-BIAS) - IW'(lead_zeros(f));
    else        n = $signed({1'b0, e}) - IW'(BIAS);
  end

  always_comb begin
    if (is_nan)       res_d = {op_i[DW-1], {EW{1'b1}}, 1'b1, f[FW-2:0]};
    else if (is_inf)  res_d = {1'b0, {EW{1'b1}}, {FW{1'b0}}};
    else if (is_zero) res_d = {1'b1, {EW{1'b1}}, {FW{1'b0}}};
    else              res_d = int_to_fp(n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o <= '0;
      inv_o <= 1'b0;
      den_o <= 1'b0;
    end else begin
      res_o <= res_d;
      inv_o <= is_nan && !f[FW-1];
      den_o <= is_sub;
    end
  end

  a_r4_inv_with_qnan: assert property (@(posedge clk) disable iff (!rst_n)
    inv_o |-> (&res_o[DW-2:FW-1]) && (res_o[FW-2:0] != '0));

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_o && den_o));

  a_r8_den_band: assert property (@(posedge clk) disable iff (!rst_n)
    den_o |-> res_o[DW-1] &&
      (res_o[DW-2:FW] == EW'(BIAS + 9) || res_o[DW-2:FW] == EW'(BIAS + 10)));

  a_r9_exact_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (res_o[DW-2:FW] != {EW{1'b1}}) |-> (res_o[FW-IW-1:0] == '0));

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (res_o == '0) && !inv_o && !den_o);
endmodule

// File: tb/dp_exp_extract_test.sv
module dp_exp_extract_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op = '0;
  logic        daz = 1'b0;
  logic [63:0] res;
  logic        inv, den;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  dp_exp_extract uut (.clk(clk), .rst_n(rst_n), .op_i(op), .daz_i(daz),
                      .res_o(res), .inv_o(inv), .den_o(den));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [65:0] model(input logic [63:0] x, input logic d);
    logic [10:0] e;
    logic [51:0] f;
    int h, n;
    e = x[62:52];
    f = x[51:0];
    if (e == 11'h7FF && f != 0) return {!f[51], 1'b0, x[63], 11'h7FF, 1'b1, f[50:0]};
    if (e == 11'h7FF) return {2'b00, 64'h7FF0000000000000};
    if (e == 0 && (f == 0 || d)) return {2'b00, 64'hFFF0000000000000};
    if (e == 0) begin
      h = 0;
      for (int i = 0; i < 52; i++) if (f[i]) h = i;
      n = -1074 + h;
      return {2'b01, $realtobits(real'(n))};
    end
    n = int'(e) - 1023;
    return {2'b00, $realtobits(real'(n))};
  endfunction

  task automatic apply(input logic [63:0] x, input logic d, input string tag);
    logic [65:0] exp_v;
    @(negedge clk);
    op = x;
    daz = d;
    exp_v = model(x, d);
    @(negedge clk);
    checks++;
    if ({inv, den, res} !== exp_v) begin
      errors++;
      $display("FAIL %s op=%h daz=%0b got inv=%0b den=%0b res=%h exp inv=%0b den=%0b res=%h",
               tag, x, d, inv, den, res, exp_v[65], exp_v[64], exp_v[63:0]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] x;
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 3);
    checks++;
    if ({inv, den, res} !== 66'd0) begin
      errors++;
      $display("FAIL R1 reset got %h exp 0", {inv, den, res});
    end
    @(negedge clk);
    rst_n = 1'b1;
    apply(64'h3FF0000000000000, 1'b0, "R7 one gives +0");
    apply(64'hBFF0000000000000, 1'b0, "R2 minus one sign ignored");
    apply(64'h4000000000000000, 1'b0, "R7 two");
    apply(64'h3FE0000000000000, 1'b0, "R7 half");
    apply(64'h7FEFFFFFFFFFFFFF, 1'b0, "R7 max normal");
    apply(64'h0010000000000000, 1'b0, "R7 min normal");
    apply(64'hC123456789ABCDEF, 1'b0, "R2 negative normal");
    apply(64'h0000000000000000, 1'b0, "R6 plus zero");
    apply(64'h8000000000000000, 1'b0, "R6 minus zero");
    apply(64'h7FF0000000000000, 1'b0, "R5 plus inf");
    apply(64'hFFF0000000000000, 1'b0, "R5 minus inf");
    apply(64'h7FF8000000000123, 1'b0, "R3 R4 quiet nan");
    apply(64'hFFF0000000000ABC, 1'b0, "R3 R4 signaling nan");
    apply(64'h7FF0000000000001, 1'b1, "R4 signaling nan daz");
    apply(64'h0008000000000000, 1'b0, "R8 sub top bit");
    apply(64'h0000000000000001, 1'b0, "R8 sub lowest bit");
    apply(64'h8000000000000010, 1'b0, "R8 negative sub");
    apply(64'h0008000000000000, 1'b1, "R6 daz sub");
    apply(64'h0010000000000000, 1'b1, "R6 daz normal unaffected");
    for (int i = 0; i < 52; i++)
      apply(64'h1 << i, 1'b0, "R8 R9 sub sweep");
    for (int i = 0; i < 3000; i++) begin
      x = {$urandom, $urandom};
      case ($urandom % 6)
        0: x[62:52] = 11'h7FF;
        1: x[62:52] = 11'h000;
        2: x[51:0] = x[51:0] >> ($urandom % 52);
        default: ;
      endcase
      if (x[62:52] == 0 && ($urandom % 3) == 0) x[51:0] = x[51:0] >> ($urandom % 52);
      apply(x, 1'($urandom), "R2 R7 R9 random");
    end
    rst_n = 1'b0;
    #1;
    checks++;
    if ({inv, den, res} !== 66'd0) begin
      errors++;
      $display("FAIL R1 reset reassert got %h exp 0", {inv, den, res});
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule